// File: doc/BRIEF.md
# Configuration Image Header Parser

This block reads a configuration image that arrives one byte per beat over a valid/ready stream. From the header it works out where the payload begins and where the table of component sizes begins, and it captures the 16-bit component count. A single byte counter tracks the position in the image. The block holds only the handful of bytes it needs, so the image is never buffered.

Software or a sequencer pulses `startIn` and then streams the image in. The block deasserts `byteReady` as soon as it has what it needs, or as soon as it detects a fault. One cycle after the final accepted beat it pulses `doneOut`, and `errOut` reports whether the parse failed. The results stay on the outputs until the next start pulse, so the component count and offsets can be read at leisure. The consumer then streams the rest of the image elsewhere.

Top module: `cfgHeaderParser`

## Requirements
- R1: After reset `byteReady`, `doneOut`, `errOut`, `payOffs`, `sizeOffs` and `compCount` are all zero. A `startIn` pulse clears the results and raises `byteReady` on the following cycle.
- R2: The header length is the byte at image position 24. A value below 26 ends the parse with an error on the beat that carries it. A value of 26 is accepted.
- R3: The record count is the byte at position (header length − 1). A count of zero ends the parse with an error on that beat.
- R4: Records are 9 bytes each and start at position (header length). Byte 0 of a record is an ID, and bytes 1..4 are a 32-bit offset with the least significant byte first. ID 8 loads `payOffs` and ID 5 loads `sizeOffs`. Every other ID is skipped. A later record with the same ID overwrites the earlier value, even when the new value is zero.
- R5: Once both captured offsets are non-zero, the table scan stops and later records have no effect. On success both offsets are non-zero.
- R6: `compCount` is taken from positions 55 (low byte) and 56 (high byte). Completion is never signalled before position 56 has been accepted.
- R7: If the last record has been consumed while either offset is still zero, the parse ends with an error on the last byte of that record.
- R8: `byteLast` on an accepted beat that does not complete the parse ends it with an error. `byteLast` on the completing beat still gives a success.
- R9: `doneOut` is a one-cycle pulse, one cycle after the final accepted beat. From that cycle on `byteReady` is low, further beats are ignored, and all results hold until the next start.
- R10: Cycles with `byteValid` low do not advance the position, so the results do not depend on gaps in the stream.
- R11: A start pulse in the middle of a parse abandons it and begins a fresh parse at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Begin a new parse; clears results |
| byteValid | input | 1 | Image byte present |
| byteData | input | 8 | Image byte |
| byteLast | input | 1 | Marks the final byte of the image |
| byteReady | output | 1 | Block accepts a byte this cycle |
| doneOut | output | 1 | One-cycle pulse when the parse ends |
| errOut | output | 1 | Parse failed; held until next start |
| payOffs | output | 32 | Start offset of the payload |
| sizeOffs | output | 32 | Start offset of the component-size table |
| compCount | output | 16 | Number of components |

## Verification
The hardest case to reach is a lookup table that finishes well before position 56. In that case the offsets are already final, but completion has to wait for the count bytes. The stimulus builds an image with a 30-byte header and two records, so both IDs are found by byte 44 and the stream then has to run on to byte 56. The bench also covers the early exit with later duplicate IDs, a zero offset that a later record replaces, and a restart in the middle of a parse. All of these run against a reference that re-parses the received bytes on every beat.

// File: rtl/hdrParsePkg.sv
package hdrParsePkg;
  // control -> datapath
  typedef struct packed {
    logic clr;   // start of a new parse
    logic take;  // a byte is accepted this cycle
  } ctrlStrb_t;

  // datapath -> control (valid when take is high)
  typedef struct packed {
    logic failNow;    // this byte proves the header bad
    logic finishNow;  // this byte completes the parse
  } dpFlags_t;
endpackage

// File: rtl/hdrParseData.sv
module hdrParseData
  import hdrParsePkg::*;
#(
  parameter int OFFS_W    = 32,
  parameter int POS_W     = 16,
  parameter int CNT_W     = 16,
  parameter int LEN_POS   = 24,
  parameter int CNT_POS   = 55,
  parameter int PAY_ID    = 8,
  parameter int SIZE_ID   = 5,
  parameter int REC_BYTES = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [7:0]        byteData,
  output dpFlags_t          flags,
  output logic [OFFS_W-1:0] payOffs,
  output logic [OFFS_W-1:0] sizeOffs,
  output logic [CNT_W-1:0]  compCount
);
  localparam int OFFS_BYTES = OFFS_W / 8;
  localparam int ASM_W      = OFFS_W - 8;
  localparam int REC_W      = $clog2(REC_BYTES);
  localparam logic [POS_W-1:0] LEN_AT   = POS_W'(LEN_POS);
  localparam logic [POS_W-1:0] CNT_LO   = POS_W'(CNT_POS);
  localparam logic [POS_W-1:0] CNT_HI   = POS_W'(CNT_POS + 1);
  localparam logic [7:0]       MIN_LEN  = 8'(LEN_POS + 2);
  localparam logic [7:0]       PAY_TAG  = 8'(PAY_ID);
  localparam logic [7:0]       SIZE_TAG = 8'(SIZE_ID);
  localparam logic [REC_W-1:0] OFF_LAST = REC_W'(OFFS_BYTES);
  localparam logic [REC_W-1:0] REC_LAST = REC_W'(REC_BYTES - 1);

  logic [POS_W-1:0] pos;
  logic [7:0]       hdrLen;
  logic [7:0]       recLeft;
  logic [REC_W-1:0] recByte;
  logic [7:0]       idReg;
  logic [ASM_W-1:0] asmReg;
  logic             tblDone;

  logic [POS_W-1:0]  hdrLenExt;
  logic              atLen, lenBad, atCnt, zeroRecs, inTable;
  logic              commit, recEnd, tableFail, hitBoth;
  logic [OFFS_W-1:0] fullOffs, nextPay, nextSize;

  always_comb begin
    hdrLenExt = POS_W'(hdrLen);
    atLen     = (pos == LEN_AT);
    lenBad    = atLen && (byteData < MIN_LEN);
    atCnt     = (pos > LEN_AT) && (pos == hdrLenExt - POS_W'(1));
    zeroRecs  = atCnt && (byteData == 8'd0);
    inTable   = (pos > LEN_AT) && (pos >= hdrLenExt) && (recLeft != 8'd0) && !tblDone;
    commit    = inTable && (recByte == OFF_LAST);
    recEnd    = inTable && (recByte == REC_LAST);
    tableFail = recEnd && (recLeft == 8'd1);
    fullOffs  = {byteData, asmReg};
    nextPay   = (commit && idReg == PAY_TAG)  ? fullOffs : payOffs;
    nextSize  = (commit && idReg == SIZE_TAG) ? fullOffs : sizeOffs;
    hitBoth   = commit && (nextPay != '0) && (nextSize != '0);
    flags.failNow   = lenBad || zeroRecs || tableFail;
    flags.finishNow = (tblDone || hitBoth) && (pos >= CNT_HI);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clr) begin
      pos       <= '0;
      hdrLen    <= '0;
      recLeft   <= '0;
      recByte   <= '0;
      idReg     <= '0;
      asmReg    <= '0;
      tblDone   <= 1'b0;
      payOffs   <= '0;
      sizeOffs  <= '0;
      compCount <= '0;
    end else if (strb.take) begin
      pos <= pos + POS_W'(1);
      if (atLen) hdrLen <= byteData;
      if (atCnt) recLeft <= byteData;
      if (pos == CNT_LO) compCount[7:0]  <= byteData;
      if (pos == CNT_HI) compCount[15:8] <= byteData;
      if (inTable) begin
        if (recByte == '0) idReg <= byteData;
        if (recByte != '0 && recByte < OFF_LAST) asmReg <= {byteData, asmReg[ASM_W-1:8]};
        recByte  <= recEnd ? '0 : recByte + REC_W'(1);
        if (recEnd) recLeft <= recLeft - 8'd1;
        payOffs  <= nextPay;
        sizeOffs <= nextSize;
        if (hitBoth) tblDone <= 1'b1;
      end
    end
  end

  // R10: the position moves by exactly one per accepted byte
  a_r10_pos_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> pos == $past(pos) + POS_W'(1));

  // R5: once both offsets are found nothing later changes them
  a_r5_frozen_after_both: assert property (@(posedge clk) disable iff (!rstN)
    (tblDone && !strb.clr) |=> ($stable(payOffs) && $stable(sizeOffs)));
endmodule

// File: rtl/hdrParseCtrl.sv
module hdrParseCtrl
  import hdrParsePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  input  logic      byteValid,
  input  logic      byteLast,
  input  dpFlags_t  flags,
  output ctrlStrb_t strb,
  output logic      byteReady,
  output logic      doneOut,
  output logic      errOut
);
  logic running;
  logic fire;
  logic ending;

  always_comb begin
    fire      = byteValid && running && !startIn;
    ending    = fire && (flags.failNow || flags.finishNow || byteLast);
    strb.clr  = startIn;
    strb.take = fire;
    byteReady = running;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      doneOut <= 1'b0;
      errOut  <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      if (startIn) begin
        running <= 1'b1;
        errOut  <= 1'b0;
      end else if (ending) begin
        running <= 1'b0;
        doneOut <= 1'b1;
        errOut  <= flags.failNow || !flags.finishNow;
      end
    end
  end

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R9: no byte is accepted once done is signalled
  a_r9_no_ready_at_done: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !byteReady);

  // R7: an error only appears together with the done pulse
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errOut) |-> doneOut);
endmodule

// File: rtl/cfgHeaderParser.sv
module cfgHeaderParser
  import hdrParsePkg::*;
#(
  parameter int OFFS_W = 32,
  parameter int POS_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              byteLast,
  output logic              byteReady,
  output logic              doneOut,
  output logic              errOut,
  output logic [OFFS_W-1:0] payOffs,
  output logic [OFFS_W-1:0] sizeOffs,
  output logic [CNT_W-1:0]  compCount
);
  ctrlStrb_t strb;
  dpFlags_t  flags;

  hdrParseCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .byteValid(byteValid),
    .byteLast(byteLast), .flags(flags), .strb(strb), .byteReady(byteReady),
    .doneOut(doneOut), .errOut(errOut)
  );

  hdrParseData #(.OFFS_W(OFFS_W), .POS_W(POS_W), .CNT_W(CNT_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData), .flags(flags),
    .payOffs(payOffs), .sizeOffs(sizeOffs), .compCount(compCount)
  );

  // R5: a successful parse always reports two non-zero offsets
  a_r5_success_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !errOut) |-> (payOffs != '0 && sizeOffs != '0));
endmodule

// File: tb/test_cfgHeaderParser.sv
module test_cfgHeaderParser;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN, startIn, byteValid, byteLast;
  logic [7:0]  byteData;
  logic        byteReady, doneOut, errOut;
  logic [31:0] payOffs, sizeOffs;
  logic [15:0] compCount;

  cfgHeaderParser i_cfgHeaderParser (
    .clk(clk), .rstN(rstN), .startIn(startIn), .byteValid(byteValid),
    .byteData(byteData), .byteLast(byteLast), .byteReady(byteReady),
    .doneOut(doneOut), .errOut(errOut), .payOffs(payOffs),
    .sizeOffs(sizeOffs), .compCount(compCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  logic [7:0] img[$];
  logic [7:0] seen[$];
  int recId[$];
  int recOff[$];

  // reference state
  bit mRun = 0, mDone = 0, mErr = 0, mOk = 0, mZero = 1;
  logic [31:0] ePay, eSz;
  logic [15:0] eCnt;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // 0 = need more bytes, 1 = success, 2 = error
  function automatic int parseSeen(output logic [31:0] p, output logic [31:0] s);
    int n, hl, rc, base, tEnd;
    bit found;
    n = seen.size(); p = 0; s = 0; found = 0; tEnd = 0;
    if (n <= 24) return 0;
    hl = seen[24];
    if (hl < 26) return 2;
    if (n < hl) return 0;
    rc = seen[hl-1];
    if (rc == 0) return 2;
    for (int i = 0; i < rc; i++) begin
      base = hl + 9*i;
      if (n < base + 5) return 0;
      if (seen[base] == 8'd8) p = {seen[base+4], seen[base+3], seen[base+2], seen[base+1]};
      if (seen[base] == 8'd5) s = {seen[base+4], seen[base+3], seen[base+2], seen[base+1]};
      if (p != 0 && s != 0) begin found = 1; tEnd = base + 5; break; end
    end
    if (!found) return (n >= hl + 9*rc) ? 2 : 0;
    return (n >= 57 && n >= tEnd) ? 1 : 0;
  endfunction

  task automatic compareAll(string tag);
    check(tag, "byteReady", 32'(byteReady), 32'(mRun));
    check(tag, "doneOut",   32'(doneOut),   32'(mDone));
    check(tag, "errOut",    32'(errOut),    32'(mErr));
    if (mZero) begin
      check(tag, "payOffs cleared",   payOffs,   0);
      check(tag, "sizeOffs cleared",  sizeOffs,  0);
      check(tag, "compCount cleared", 32'(compCount), 0);
    end else if (mOk && !mRun) begin
      check(tag, "payOffs",   payOffs,   ePay);
      check(tag, "sizeOffs",  sizeOffs,  eSz);
      check(tag, "compCount", 32'(compCount), 32'(eCnt));
    end
  endtask

  task automatic cycle(bit st, bit v, logic [7:0] d, bit lst, string tag);
    int r;
    logic [31:0] p, s;
    startIn = st; byteValid = v; byteData = d; byteLast = lst;
    mDone = 0; mZero = 0;
    if (st) begin
      mRun = 1; mErr = 0; mOk = 0; mZero = 1; seen.delete();
    end else if (mRun && v) begin
      seen.push_back(d);
      r = parseSeen(p, s);
      if (r != 0 || lst) begin
        mRun = 0; mDone = 1; mErr = (r != 1);
        if (r == 1) begin
          mOk = 1; ePay = p; eSz = s; eCnt = {seen[56], seen[55]};
        end
      end
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic build(int hl, int total, logic [15:0] cnt);
    logic [31:0] o;
    img.delete();
    for (int i = 0; i < total; i++) img.push_back(8'((i*37 + 11) ^ 8'h5A));
    img[24] = 8'(hl);
    img[55] = cnt[7:0];
    img[56] = cnt[15:8];
    if (hl >= 26) img[hl-1] = 8'(recId.size());
    for (int k = 0; k < recId.size(); k++) begin
      o = recOff[k];
      img[hl + 9*k]     = 8'(recId[k]);
      img[hl + 9*k + 1] = o[7:0];
      img[hl + 9*k + 2] = o[15:8];
      img[hl + 9*k + 3] = o[23:16];
      img[hl + 9*k + 4] = o[31:24];
    end
  endtask

  task automatic addRec(int id, int off);
    recId.push_back(id); recOff.push_back(off);
  endtask

  task automatic clearRecs();
    recId.delete(); recOff.delete();
  endtask

  // feed up to 'upto' bytes; gaps inserts idle cycles; lastAtEnd flags the final byte
  task automatic feed(string tag, int upto, bit gaps, bit lastAtEnd, bit restart);
    if (restart) cycle(1, 0, 8'h00, 0, tag);
    for (int i = 0; i < upto && i < img.size(); i++) begin
      if (!mRun) break;
      if (gaps && (i % 3 == 1)) cycle(0, 0, 8'hFF, 0, tag);
      cycle(0, 1, img[i], lastAtEnd && (i == img.size() - 1), tag);
    end
    // idle cycles: valid high is offered only when the parse has ended (R9)
    for (int j = 0; j < 4; j++) cycle(0, !mRun, 8'hA5, 0, tag);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL R10 watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rstN = 0; startIn = 0; byteValid = 0; byteData = 0; byteLast = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    mZero = 1;
    compareAll("R1");
    cycle(0, 1, 8'h33, 0, "R1");

    // R4: ignored ID, then size table and payload records
    clearRecs(); addRec(1, 32'h11111111); addRec(5, 32'h1234); addRec(8, 32'hABCDEF);
    build(71, 120, 16'h0203);
    feed("R4", 120, 0, 0, 1);

    // R5: early exit, later duplicates must not matter
    clearRecs(); addRec(8, 32'h100); addRec(5, 32'h200); addRec(8, 32'h300); addRec(5, 32'h400);
    build(60, 120, 16'h0010);
    feed("R5", 120, 0, 0, 1);

    // R4 + R10: zero offset replaced later, with gaps in the stream
    clearRecs(); addRec(8, 0); addRec(8, 32'h55); addRec(3, 32'h77); addRec(8, 32'h66); addRec(5, 32'h99);
    build(64, 130, 16'h4321);
    feed("R10", 130, 1, 0, 1);

    // R6: table finished at byte 44, completion must wait for byte 56
    clearRecs(); addRec(5, 32'hA0); addRec(8, 32'hB0);
    build(30, 80, 16'hBEEF);
    feed("R6", 80, 0, 0, 1);

    // R7: payload seen but size table never found
    clearRecs(); addRec(8, 32'h10); addRec(2, 32'h20); addRec(8, 32'h30);
    build(40, 90, 16'h0001);
    feed("R7", 90, 0, 0, 1);

    // R2: header length too short
    clearRecs();
    build(20, 60, 16'h0001);
    feed("R2", 60, 0, 0, 1);

    // R2: minimum legal header length
    clearRecs(); addRec(5, 1); addRec(8, 2);
    build(26, 70, 16'h0707);
    feed("R2", 70, 0, 0, 1);

    // R3: zero records
    clearRecs();
    build(50, 90, 16'h0001);
    feed("R3", 90, 0, 0, 1);

    // R8: stream ends in the middle of the table
    clearRecs(); addRec(1, 32'h11111111); addRec(5, 32'h1234); addRec(8, 32'hABCDEF);
    build(71, 80, 16'h0203);
    feed("R8", 80, 0, 1, 1);

    // R8: stream ends exactly on the completing byte
    build(71, 94, 16'h0203);
    feed("R8", 94, 0, 1, 1);

    // R11: restart in the middle of a parse
    build(71, 120, 16'h0203);
    feed("R11", 40, 0, 0, 1);
    clearRecs(); addRec(5, 32'hA0); addRec(8, 32'hB0);
    build(30, 80, 16'hBEEF);
    feed("R11", 80, 0, 0, 1);

    // R9: results held through idle cycles with valid high
    for (int j = 0; j < 5; j++) cycle(0, 1, 8'h5C, 0, "R9");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule